// File: doc/BRIEF.md
# Bridge System-Error Reporting Controller

This block sits beside the transaction engines of a two-sided bus bridge. It collects single-cycle failure reports from those engines, filters them through a per-source disable mask, records each accepted failure in a sticky status register, and raises a one-cycle active-high system-error pulse toward the initiating bus. Any time it raises that pulse, it also sets a summary flag in a secondary status register.

There are two more paths that can raise the pulse. A system error that arrives from the secondary side is forwarded only when two separate enable bits are both set. An address parity error, or a target-abort transaction, raises the pulse only when parity-error response is enabled. A parity-mode input chooses between passing parity errors through and having the bridge generate parity itself. In the generate mode, target-bus parity errors on posted writes are not reported. Software reaches the three registers through a simple port: byte offset, write data, write strobe, and combinational read data.

Top module: `bridge_syserr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pulse output is 0 and the mask, status and summary registers all read 0.
- R2: The mask register is at offset 0x64. Bits 1 to 6 can be read and written. Bit 0 and bits 7 to 15 always read 0, and writes to them have no effect.
- R3: evt_i[k] stands for source bit k+1. When the mask bit for that source is 0, an event pulse sets status bit k+1 at offset 0x6A and drives syserr_o high in the next cycle. The sources are: bit 1 parity error on a posted write, bit 2 posted-write retry timeout, bit 3 posted-write target abort, bit 4 posted-write master abort, bit 5 delayed-write retry timeout, and bit 6 delayed-read retry timeout.
- R4: When the mask bit for a source is 1, an event from that source sets no status bit and produces no pulse.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits 0 and 7 to 15 read 0.
- R6: If an event arrives in the same cycle as a write that clears its status bit, the bit stays 1.
- R7: Each pulse on syserr_o lasts one cycle. Events that arrive together produce one pulse, and every one of their status bits is set.
- R8: Every pulse sets bit 14 of offset 0x1E. Writing 1 to that bit clears it. If a pulse is raised in the same cycle as that clear, the bit stays 1.
- R9: A system error from the secondary side raises a pulse only when cmd_serr_en_i and bctl_serr_fwd_i are both 1. It sets no bit at 0x6A.
- R10: When cmd_perr_resp_i is 1, addr_perr_i or tgt_abort_i raises a pulse. When cmd_perr_resp_i is 0, neither one does.
- R11: When diag_parity_gen_i is 1, source bit 1 (posted-write parity error) neither sets status nor raises a pulse. When it is 0, that source behaves as in R3.
- R12: Any offset other than 0x64, 0x6A and 0x1E reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| evt_i | input | 6 | Failure event pulses; index k maps to source bit k+1 |
| sec_serr_i | input | 1 | System error arriving from the secondary side |
| addr_perr_i | input | 1 | Address parity error pulse |
| tgt_abort_i | input | 1 | Target-abort transaction pulse |
| cmd_serr_en_i | input | 1 | Command-register system-error enable |
| cmd_perr_resp_i | input | 1 | Command-register parity-error response |
| bctl_serr_fwd_i | input | 1 | Bridge-control secondary forwarding enable |
| diag_parity_gen_i | input | 1 | Parity mode: 0 passes parity errors through, 1 generates parity |
| syserr_o | output | 1 | One-cycle system-error pulse |

## Verification
Two pairs of actions can land on the same clock edge. An event can set a status bit while software writes 1 to clear that bit, and a pulse can set the summary flag while software writes 1 to clear it. Directed steps raise the event in the very cycle that the write strobe is high. The expected result is that the bit reads 1 afterwards, and the same holds for the summary flag. A random phase mixes writes, events and forwarding inputs, so these collisions also occur on their own. A behavioural model compares the pulse and the read data on every clock, which judges each collision.

// File: rtl/bsc_pkg.sv
// Shared constants for the bridge system-error reporting controller.
// Assumes an 8-bit byte-offset register space and 16-bit registers.
package bsc_pkg;
    localparam int BSC_ADDR_W   = 8;
    localparam int BSC_DATA_W   = 16;
    localparam int BSC_N_EVT    = 6;
    localparam int BSC_EVT_LSB  = 1;   // status/mask bit of evt index 0
    localparam int BSC_SUM_BIT  = 14;  // summary flag position at the summary offset
    localparam int BSC_PAR_IDX  = 0;   // event index of the posted-write parity source
    localparam logic [7:0] BSC_OFS_MASK = 8'h64;
    localparam logic [7:0] BSC_OFS_STAT = 8'h6A;
    localparam logic [7:0] BSC_OFS_SUM  = 8'h1E;
endpackage

// File: rtl/bsc_mask_reg.sv
// Per-source disable mask register.
// It loads the mask bits from the write field whenever wr_en is high.
// Reset clears every bit, which leaves every source enabled.
module bsc_mask_reg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] mask_q
);
    // Load on write; synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_bits;
    end
endmodule

// File: rtl/bsc_sticky_bits.sv
// A row of sticky bits with write-one-to-clear.
// Each bit is set by set_i and cleared by clr_i.
// When both are high in the same cycle, the set wins.
module bsc_sticky_bits #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One sticky flop, with set taking priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (set_i[i]) q[i] <= 1'b1;
            else if (clr_i[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/bsc_cause_merge.sv
// Merges every error cause into per-source hits and a single fire request.
// The logic is purely combinational; the caller registers the result.
// In parity-generate mode, the parity source selected by PAR_IDX is suppressed.
module bsc_cause_merge #(
    parameter int N       = 6,
    parameter int PAR_IDX = 0
) (
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] mask_i,
    input  logic         parity_gen_i,
    input  logic         sec_serr_i,
    input  logic         serr_en_i,
    input  logic         fwd_en_i,
    input  logic         addr_perr_i,
    input  logic         tgt_abort_i,
    input  logic         perr_resp_i,
    output logic [N-1:0] hit_o,
    output logic         fire_o
);
    logic [N-1:0] src_live;
    logic         fwd_hit;
    logic         par_hit;

    for (genvar i = 0; i < N; i++) begin : g_live
        if (i == PAR_IDX) begin : g_par
            assign src_live[i] = ~parity_gen_i;
        end else begin : g_other
            assign src_live[i] = 1'b1;
        end
    end

    // Decide which sources are accepted and whether any cause fires.
    always_comb begin
        hit_o   = evt_i & ~mask_i & src_live;
        fwd_hit = sec_serr_i & serr_en_i & fwd_en_i;
        par_hit = perr_resp_i & (addr_perr_i | tgt_abort_i);
        fire_o  = (|hit_o) | fwd_hit | par_hit;
    end
endmodule

// File: rtl/bridge_syserr_ctrl.sv
// Top of the bridge system-error reporting controller.
// It holds the disable mask, the sticky event status and the summary flag.
// It produces a registered one-cycle pulse for any accepted cause.
// Assumes event inputs are single-cycle pulses, synchronous to clk.
module bridge_syserr_ctrl #(
    parameter int         ADDR_W   = bsc_pkg::BSC_ADDR_W,
    parameter int         DATA_W   = bsc_pkg::BSC_DATA_W,
    parameter int         N_EVT    = bsc_pkg::BSC_N_EVT,
    parameter int         EVT_LSB  = bsc_pkg::BSC_EVT_LSB,
    parameter int         SUM_BIT  = bsc_pkg::BSC_SUM_BIT,
    parameter int         PAR_IDX  = bsc_pkg::BSC_PAR_IDX,
    parameter logic [7:0] OFS_MASK = bsc_pkg::BSC_OFS_MASK,
    parameter logic [7:0] OFS_STAT = bsc_pkg::BSC_OFS_STAT,
    parameter logic [7:0] OFS_SUM  = bsc_pkg::BSC_OFS_SUM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic              sec_serr_i,
    input  logic              addr_perr_i,
    input  logic              tgt_abort_i,
    input  logic              cmd_serr_en_i,
    input  logic              cmd_perr_resp_i,
    input  logic              bctl_serr_fwd_i,
    input  logic              diag_parity_gen_i,
    output logic              syserr_o
);
    localparam int EVT_MSB = EVT_LSB + N_EVT - 1;

    logic              hit_mask, hit_stat, hit_sum;
    logic [N_EVT-1:0]  wr_field;
    logic [N_EVT-1:0]  mask_q;
    logic [N_EVT-1:0]  stat_q;
    logic [N_EVT-1:0]  evt_hit;
    logic [N_EVT-1:0]  stat_clr;
    logic              fire;
    logic              sec_q;
    logic              syserr_q;
    logic              unused_wbits;

    // Decode the offset and pull out the event field of the write data.
    always_comb begin
        hit_mask = (reg_addr == ADDR_W'(OFS_MASK));
        hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
        hit_sum  = (reg_addr == ADDR_W'(OFS_SUM));
        wr_field = reg_wdata[EVT_MSB:EVT_LSB];
        stat_clr = (reg_we && hit_stat) ? wr_field : '0;
    end

    assign unused_wbits = ^reg_wdata;

    bsc_mask_reg #(.N(N_EVT)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we & hit_mask),
        .wr_bits (wr_field),
        .mask_q  (mask_q)
    );

    bsc_cause_merge #(.N(N_EVT), .PAR_IDX(PAR_IDX)) u_merge (
        .evt_i        (evt_i),
        .mask_i       (mask_q),
        .parity_gen_i (diag_parity_gen_i),
        .sec_serr_i   (sec_serr_i),
        .serr_en_i    (cmd_serr_en_i),
        .fwd_en_i     (bctl_serr_fwd_i),
        .addr_perr_i  (addr_perr_i),
        .tgt_abort_i  (tgt_abort_i),
        .perr_resp_i  (cmd_perr_resp_i),
        .hit_o        (evt_hit),
        .fire_o       (fire)
    );

    bsc_sticky_bits #(.W(N_EVT)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_hit),
        .clr_i (stat_clr),
        .q     (stat_q)
    );

    bsc_sticky_bits #(.W(1)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fire),
        .clr_i (reg_we & hit_sum & reg_wdata[SUM_BIT]),
        .q     (sec_q)
    );

    // Register the merged cause so that the pulse is clean and lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) syserr_q <= 1'b0;
        else        syserr_q <= fire;
    end

    assign syserr_o = syserr_q;

    // Read multiplexer; unused bits and unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (hit_mask)      reg_rdata[EVT_MSB:EVT_LSB] = mask_q;
        else if (hit_stat) reg_rdata[EVT_MSB:EVT_LSB] = stat_q;
        else if (hit_sum)  reg_rdata[SUM_BIT]         = sec_q;
    end
endmodule

// File: rtl/bsc_checker.sv
// Property checker for bridge_syserr_ctrl; it is attached with bind below.
// It observes the ports plus the internal status and summary state.
module bsc_checker #(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 16,
    parameter int         N_EVT    = 6,
    parameter int         EVT_LSB  = 1,
    parameter logic [7:0] OFS_MASK = 8'h64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_EVT-1:0]  evt_i,
    input logic              sec_serr_i,
    input logic              addr_perr_i,
    input logic              tgt_abort_i,
    input logic              cmd_serr_en_i,
    input logic              cmd_perr_resp_i,
    input logic              bctl_serr_fwd_i,
    input logic              syserr_o,
    input logic [N_EVT-1:0]  stat_q,
    input logic              sec_q
);
    localparam int EVT_MSB = EVT_LSB + N_EVT - 1;

    // R1: the cycle after reset is sampled low, no pulse is present
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> !syserr_o);

    // R2: the reserved mask bits read zero
    assert_mask_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_MASK)) |->
            (reg_rdata[EVT_LSB-1:0] == '0) && (reg_rdata[DATA_W-1:EVT_MSB+1] == '0));

    // R4: a status bit can rise only after its own event input was seen
    assert_status_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0));

    // R7: every pulse has a cause in the previous cycle
    assert_pulse_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        syserr_o |-> $past((|evt_i) | sec_serr_i | addr_perr_i | tgt_abort_i));

    // R8: the summary flag is set whenever a pulse is out
    assert_summary_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        syserr_o |-> sec_q);

    // R9: a pulse from forwarding alone needs both enables
    assert_forward_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (syserr_o && !$past(|evt_i) && !$past(addr_perr_i | tgt_abort_i)) |->
            $past(sec_serr_i & cmd_serr_en_i & bctl_serr_fwd_i));

    // R10: a pulse from parity or abort alone needs parity-error response
    assert_parity_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (syserr_o && !$past(|evt_i) && !$past(sec_serr_i)) |->
            $past(cmd_perr_resp_i & (addr_perr_i | tgt_abort_i)));
endmodule

bind bridge_syserr_ctrl bsc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT),
    .EVT_LSB(EVT_LSB), .OFS_MASK(OFS_MASK)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_addr        (reg_addr),
    .reg_rdata       (reg_rdata),
    .evt_i           (evt_i),
    .sec_serr_i      (sec_serr_i),
    .addr_perr_i     (addr_perr_i),
    .tgt_abort_i     (tgt_abort_i),
    .cmd_serr_en_i   (cmd_serr_en_i),
    .cmd_perr_resp_i (cmd_perr_resp_i),
    .bctl_serr_fwd_i (bctl_serr_fwd_i),
    .syserr_o        (syserr_o),
    .stat_q          (stat_q),
    .sec_q           (sec_q)
);

// File: tb/tb_bridge_syserr_ctrl.sv
// Self-checking bench for bridge_syserr_ctrl.
// A behavioural model is compared on every clock, alongside directed steps.
module tb_bridge_syserr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic [5:0]  evt_i = '0;
    logic        sec_serr_i = 1'b0, addr_perr_i = 1'b0, tgt_abort_i = 1'b0;
    logic        cmd_serr_en_i = 1'b0, cmd_perr_resp_i = 1'b0;
    logic        bctl_serr_fwd_i = 1'b0, diag_parity_gen_i = 1'b0;
    logic        syserr_o;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // Model state
    int m_mask = 0, m_stat = 0, m_sum = 0, m_pulse = 0;

    bridge_syserr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .sec_serr_i(sec_serr_i), .addr_perr_i(addr_perr_i), .tgt_abort_i(tgt_abort_i),
        .cmd_serr_en_i(cmd_serr_en_i), .cmd_perr_resp_i(cmd_perr_resp_i),
        .bctl_serr_fwd_i(bctl_serr_fwd_i), .diag_parity_gen_i(diag_parity_gen_i),
        .syserr_o(syserr_o)
    );

    always #10 clk = ~clk;

    function automatic int exp_read(input logic [7:0] a);
        if (a == 8'h64) return m_mask;
        if (a == 8'h6A) return m_stat;
        if (a == 8'h1E) return m_sum << 14;
        return 0;
    endfunction

    // Behavioural model of the registers and the pulse
    always @(posedge clk) begin
        int hit, fire;
        if (!rst_n) begin
            m_mask = 0; m_stat = 0; m_sum = 0; m_pulse = 0;
        end else begin
            hit = 0;
            for (int k = 0; k < 6; k++)
                if (evt_i[k] && ((m_mask >> (k + 1)) & 1) == 0 && !(k == 0 && diag_parity_gen_i))
                    hit = hit | (1 << (k + 1));
            fire = (hit != 0) || (sec_serr_i && cmd_serr_en_i && bctl_serr_fwd_i)
                   || (cmd_perr_resp_i && (addr_perr_i || tgt_abort_i));
            if (reg_we && reg_addr == 8'h6A) m_stat = m_stat & ~(int'(reg_wdata) & 'h7E);
            m_stat = m_stat | hit;
            if (fire) m_sum = 1;
            else if (reg_we && reg_addr == 8'h1E && reg_wdata[14]) m_sum = 0;
            if (reg_we && reg_addr == 8'h64) m_mask = int'(reg_wdata) & 'h7E;
            m_pulse = fire;
        end
    end

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            checks++;
            if (int'(syserr_o) != m_pulse) begin
                bad++;
                $display("FAIL R3 model pulse: actual=%0d expected=%0d", syserr_o, m_pulse);
            end
            checks++;
            if (int'(reg_rdata) != exp_read(reg_addr)) begin
                bad++;
                $display("FAIL R2 model read @%h: actual=%h expected=%h",
                         reg_addr, reg_rdata, exp_read(reg_addr));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        reg_we = 0; evt_i = '0; sec_serr_i = 0; addr_perr_i = 0; tgt_abort_i = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1; tick(); reg_we = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input int exp);
        reg_addr = a; @(negedge clk); chk(tag, int'(reg_rdata), exp); tick();
    endtask

    // The stimulus is already set; the edge registers it, then the pulse is sampled.
    task automatic pulse_chk(input string tag, input int exp);
        tick(); idle(); @(negedge clk); chk(tag, int'(syserr_o), exp); tick();
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 pulse in reset", int'(syserr_o), 0);
        rst_n = 1; cmp_on = 1;
        tick();
        rd_chk("R1 mask reset", 8'h64, 0);
        rd_chk("R1 status reset", 8'h6A, 0);
        rd_chk("R1 summary reset", 8'h1E, 0);

        wr(8'h64, 16'hFFFF);
        rd_chk("R2 mask write all", 8'h64, 'h007E);
        rd_chk("R12 unmapped offset", 8'h10, 0);
        wr(8'h64, 16'h0000);

        evt_i = 6'b000100;
        pulse_chk("R3 target abort pulse", 1);
        @(negedge clk); chk("R7 pulse one cycle", int'(syserr_o), 0); tick();
        rd_chk("R3 status bit3", 8'h6A, 'h0008);
        rd_chk("R8 summary set", 8'h1E, 'h4000);

        wr(8'h6A, 16'h0000);
        rd_chk("R5 write zero keeps", 8'h6A, 'h0008);
        wr(8'h6A, 16'hFFF7);
        rd_chk("R5 other ones keep", 8'h6A, 'h0008);
        wr(8'h6A, 16'h0008);
        rd_chk("R5 write one clears", 8'h6A, 0);
        wr(8'h1E, 16'h4000);
        rd_chk("R8 summary clears", 8'h1E, 0);

        wr(8'h64, 16'h0010);
        evt_i = 6'b001000;
        pulse_chk("R4 masked no pulse", 0);
        rd_chk("R4 masked no status", 8'h6A, 0);

        evt_i = 6'b100111;
        pulse_chk("R7 joint events pulse", 1);
        @(negedge clk); chk("R7 single pulse", int'(syserr_o), 0); tick();
        rd_chk("R7 all bits set", 8'h6A, 'h004E);

        // R6: clear bit 2 in the same cycle that its event arrives
        reg_addr = 8'h6A; reg_wdata = 16'h0004; reg_we = 1; evt_i = 6'b000010;
        tick(); idle();
        rd_chk("R6 set wins", 8'h6A, 'h004E);
        // R8: clear the summary flag in the same cycle that a pulse is raised
        reg_addr = 8'h1E; reg_wdata = 16'h4000; reg_we = 1; evt_i = 6'b000001;
        tick(); idle();
        rd_chk("R8 set wins", 8'h1E, 'h4000);
        wr(8'h6A, 16'hFFFF);
        wr(8'h1E, 16'h4000);

        for (int c = 0; c < 4; c++) begin
            cmd_serr_en_i = c[0]; bctl_serr_fwd_i = c[1]; sec_serr_i = 1;
            pulse_chk("R9 forwarding gate", (c == 3) ? 1 : 0);
        end
        rd_chk("R9 no status bits", 8'h6A, 0);

        cmd_perr_resp_i = 0; addr_perr_i = 1;
        pulse_chk("R10 parity off", 0);
        cmd_perr_resp_i = 1; addr_perr_i = 1;
        pulse_chk("R10 address parity", 1);
        tgt_abort_i = 1;
        pulse_chk("R10 target abort", 1);
        cmd_perr_resp_i = 0;

        diag_parity_gen_i = 1; evt_i = 6'b000001;
        pulse_chk("R11 generate mode no pulse", 0);
        rd_chk("R11 generate mode no status", 8'h6A, 0);
        diag_parity_gen_i = 0; evt_i = 6'b000001;
        pulse_chk("R11 pass mode pulse", 1);
        rd_chk("R11 pass mode status", 8'h6A, 'h0002);

        // Random mix; the per-clock model compare checks every requirement here
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 3);
            reg_addr = (r == 0) ? 8'h64 : (r == 1) ? 8'h6A : (r == 2) ? 8'h1E : 8'h20;
            reg_wdata = 16'($urandom);
            reg_we = ($urandom_range(0, 3) == 0);
            evt_i = ($urandom_range(0, 2) == 0) ? 6'($urandom) : 6'b0;
            sec_serr_i = ($urandom_range(0, 7) == 0);
            addr_perr_i = ($urandom_range(0, 9) == 0);
            tgt_abort_i = ($urandom_range(0, 9) == 0);
            cmd_serr_en_i = 1'($urandom); bctl_serr_fwd_i = 1'($urandom);
            cmd_perr_resp_i = 1'($urandom); diag_parity_gen_i = ($urandom_range(0, 3) == 0);
            tick();
        end
        idle();
        tick(); tick();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule